// File: doc/BRIEF.md
# SDRAM Command and Mode Decoder

This block sits behind the command pins of a double-data-rate SDRAM device model or controller front end. On every rising clock edge it samples chip select, the three command strobes, the bank select and the 13-bit address bus. It turns that sample into one decoded command. The address fields are split into row, column and precharge-flag outputs.

The block keeps an open-row record for each of four banks. It rejects accesses that would break the bank rules: Active to an open bank, Read or Write to a bank with no open row, and Refresh while any row is open. It times the self-closing of a bank after an access that requests auto-precharge.

The block also holds the mode settings: burst length code, burst type and CAS latency code. Mode writes are checked against the normal form and the DLL-reset form. Any other upper-bit pattern is treated as reserved. A rejected command raises a one-cycle error flag, is reported as no-operation and changes no state.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While cs_n is 1 at a rising edge, the sample decodes as no-operation: cmd_o=0, err_o=0, and no bank, mode or address output changes.
- R2: With cs_n=0 the strobe pattern {ras_n,cas_n,we_n} maps to cmd_o as follows: 111→0 (NOP), 011→1 (Active), 101→2 (Read), 100→3 (Write), 010→4 (Precharge), 001→5 (Refresh), 000→6 (Mode write), 110→7 (Burst stop). All outputs are registered and appear after the sampling edge.
- R3: An Active command to a closed bank opens it. It sets open_o[ba], bank_o=ba and row_o=addr[12:0]. An Active command to a bank that is open or still closing is rejected: err_o=1 and cmd_o=0.
- R4: A Read or Write to an open, idle bank sets bank_o=ba, col_o=addr[9:0], ap_o=addr[10], and row_o to the row held open in that bank. A Read or Write to a closed bank is rejected with err_o=1 and cmd_o=0.
- R5: A Precharge with addr[10]=1 closes all banks. With addr[10]=0 it closes only bank ba. In both cases it sets bank_o=ba and ap_o=addr[10].
- R6: A Read or Write accepted at edge k with addr[10]=1 closes its bank at edge k+BL/2. Any Active, Read or Write to that bank at edges k+1 through k+BL/2 is rejected.
- R7: A Refresh is accepted only when all banks are closed. Otherwise it is rejected.
- R8: A mode write with ba=0 and addr[12:7]=0 loads bl_o=addr[2:0], bt_o=addr[3] and cl_o=addr[6:4], and clears any pending DLL reset.
- R9: The only legal burst-length codes are 001 (2), 010 (4) and 011 (8). The only legal CAS-latency codes are 010, 110 and 011. A mode write with any other field value is rejected and leaves the mode unchanged.
- R10: A mode write with ba=0 and addr[12:7]=000010 loads the fields, pulses dll_rst_o for one cycle and sets a DLL-reset-pending state. While that state is pending, a further DLL-reset mode write is rejected.
- R11: A mode write with ba≠0, or with addr[12:7] matching neither form, is rejected with the mode unchanged.
- R12: After reset: cmd_o=0, err_o=0, dll_rst_o=0, all banks closed, bank_o=row_o=col_o=ap_o=0, bl_o=010, bt_o=0, cl_o=010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable strobe, active low |
| ba | input | 2 | Bank select |
| addr | input | 13 | Address bus (row, column, flags, mode fields) |
| cmd_o | output | 3 | Issued command code, 0 when rejected |
| err_o | output | 1 | One-cycle flag for a rejected command |
| bank_o | output | 2 | Bank of the last Active, Read, Write or Precharge |
| row_o | output | 13 | Row of the last Active, or the open row used by the last access |
| col_o | output | 10 | Starting column of the last Read or Write |
| ap_o | output | 1 | addr[10] of the last issued command |
| bl_o | output | 3 | Burst-length code |
| bt_o | output | 1 | Burst type bit |
| cl_o | output | 3 | CAS-latency code |
| dll_rst_o | output | 1 | One-cycle DLL-reset request pulse |
| open_o | output | 4 | Per-bank open flag |

## Verification
The assertions check on every cycle that:
- a rejected command is never reported as issued;
- chip-select-high samples yield no-operation;
- Reads and Writes only follow an open bank, and Refresh only follows all banks closed;
- the mode fields stay legal and change only with a mode write;
- the DLL-reset pulse is a single cycle coincident with a mode write.

Only the bench's scenarios can show the rest. These are the exact field and row values, the auto-precharge closing edge for each burst length, the rejection of a second DLL-reset write, and the mode staying unchanged after reserved, illegal-field and non-zero-bank mode writes.

// File: rtl/sdram_dec_pkg.sv
package sdram_dec_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5,
    CMD_MRS = 3'd6,
    CMD_BST = 3'd7
  } cmd_e;

  localparam logic [2:0] BL_RESET = 3'b010;
  localparam logic [2:0] CL_RESET = 3'b010;

  function automatic logic bl_legal(input logic [2:0] code);
    return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction

  function automatic logic cl_legal(input logic [2:0] code);
    return (code == 3'b010) || (code == 3'b110) || (code == 3'b011);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_dec_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_NOP;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        3'b000:  cmd = CMD_MRS;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_tracker.sv
module sdram_bank_tracker #(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W     = 13,
  parameter int CNT_W     = 3,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             act_v,
  input  logic                             ap_v,
  input  logic [BA_W-1:0]                  bank_sel,
  input  logic [NUM_BANKS-1:0]             close_vec,
  input  logic [ROW_W-1:0]                 row_in,
  input  logic [CNT_W-1:0]                 ap_len,
  output logic [NUM_BANKS-1:0]             open_vec,
  output logic [NUM_BANKS-1:0]             busy_vec,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]  rows
);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [CNT_W-1:0] cnt_q;
    logic             hit;

    assign hit         = (bank_sel == BA_W'(b));
    assign busy_vec[b] = (cnt_q != '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        open_vec[b] <= 1'b0;
        cnt_q       <= '0;
        rows[b]     <= '0;
      end else if (close_vec[b]) begin
        open_vec[b] <= 1'b0;
        cnt_q       <= '0;
      end else if (act_v && hit) begin
        open_vec[b] <= 1'b1;
        rows[b]     <= row_in;
      end else if (ap_v && hit) begin
        cnt_q <= ap_len;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          open_vec[b] <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/sdram_mode_reg.sv
module sdram_mode_reg
  import sdram_dec_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2,
  parameter int UP_LSB = 7,
  parameter int DLL_BIT = 8,
  localparam int UP_W  = ADDR_W - UP_LSB
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mrs_req,
  input  logic [BA_W-1:0]   ba,
  input  logic [ADDR_W-1:0] addr,
  output logic              mode_ok,
  output logic [2:0]        bl_code,
  output logic              bt,
  output logic [2:0]        cl_code,
  output logic              dll_pulse
);

  localparam logic [UP_W-1:0] DLL_FORM = UP_W'(1) << (DLL_BIT - UP_LSB);

  logic [UP_W-1:0] upper;
  logic            is_normal;
  logic            is_dll;
  logic            fields_ok;
  logic            dll_pend_q;
  logic            apply;

  assign upper     = addr[ADDR_W-1:UP_LSB];
  assign is_normal = (upper == '0);
  assign is_dll    = (upper == DLL_FORM);
  assign fields_ok = bl_legal(addr[2:0]) && cl_legal(addr[6:4]);
  assign mode_ok   = (ba == '0) && fields_ok &&
                     (is_normal || (is_dll && !dll_pend_q));
  assign apply     = mrs_req && mode_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      bl_code    <= BL_RESET;
      bt         <= 1'b0;
      cl_code    <= CL_RESET;
      dll_pend_q <= 1'b0;
      dll_pulse  <= 1'b0;
    end else begin
      dll_pulse <= apply && is_dll;
      if (apply) begin
        bl_code    <= addr[2:0];
        bt         <= addr[3];
        cl_code    <= addr[6:4];
        dll_pend_q <= is_dll;
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_dec_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int ROW_W     = 13,
  parameter int COL_W     = 10,
  parameter int AP_BIT    = 10,
  localparam int BA_W     = $clog2(NUM_BANKS),
  localparam int CNT_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BA_W-1:0]      ba,
  input  logic [ADDR_W-1:0]    addr,
  output logic [2:0]           cmd_o,
  output logic                 err_o,
  output logic [BA_W-1:0]      bank_o,
  output logic [ROW_W-1:0]     row_o,
  output logic [COL_W-1:0]     col_o,
  output logic                 ap_o,
  output logic [2:0]           bl_o,
  output logic                 bt_o,
  output logic [2:0]           cl_o,
  output logic                 dll_rst_o,
  output logic [NUM_BANKS-1:0] open_o
);

  cmd_e                            raw_cmd;
  cmd_e                            issue;
  logic                            ok;
  logic                            mode_ok;
  logic [NUM_BANKS-1:0]            busy_vec;
  logic [NUM_BANKS-1:0]            close_vec;
  logic [NUM_BANKS-1:0][ROW_W-1:0] rows;
  logic [CNT_W-1:0]                ap_len;
  logic                            flag;

  assign flag = addr[AP_BIT];

  sdram_cmd_decode u_dec (
    .cs_n (cs_n),
    .ras_n(ras_n),
    .cas_n(cas_n),
    .we_n (we_n),
    .cmd  (raw_cmd)
  );

  sdram_mode_reg #(
    .ADDR_W(ADDR_W),
    .BA_W  (BA_W)
  ) u_mode (
    .clk      (clk),
    .rst      (rst),
    .mrs_req  (raw_cmd == CMD_MRS),
    .ba       (ba),
    .addr     (addr),
    .mode_ok  (mode_ok),
    .bl_code  (bl_o),
    .bt       (bt_o),
    .cl_code  (cl_o),
    .dll_pulse(dll_rst_o)
  );

  always_comb begin
    unique case (raw_cmd)
      CMD_ACT:         ok = !open_o[ba];
      CMD_RD, CMD_WR:  ok = open_o[ba] && !busy_vec[ba];
      CMD_REF:         ok = (open_o == '0);
      CMD_MRS:         ok = mode_ok;
      default:         ok = 1'b1;
    endcase
    issue = ok ? raw_cmd : CMD_NOP;
  end

  always_comb begin
    close_vec = '0;
    if (issue == CMD_PRE) begin
      if (flag) close_vec = '1;
      else      close_vec[ba] = 1'b1;
    end
  end

  assign ap_len = CNT_W'(1) << (bl_o - 3'd1);

  sdram_bank_tracker #(
    .NUM_BANKS(NUM_BANKS),
    .ROW_W    (ROW_W),
    .CNT_W    (CNT_W)
  ) u_banks (
    .clk      (clk),
    .rst      (rst),
    .act_v    (issue == CMD_ACT),
    .ap_v     (((issue == CMD_RD) || (issue == CMD_WR)) && flag),
    .bank_sel (ba),
    .close_vec(close_vec),
    .row_in   (addr[ROW_W-1:0]),
    .ap_len   (ap_len),
    .open_vec (open_o),
    .busy_vec (busy_vec),
    .rows     (rows)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o  <= CMD_NOP;
      err_o  <= 1'b0;
      bank_o <= '0;
      row_o  <= '0;
      col_o  <= '0;
      ap_o   <= 1'b0;
    end else begin
      cmd_o <= issue;
      err_o <= !ok;
      if (ok) begin
        unique case (raw_cmd)
          CMD_ACT: begin
            bank_o <= ba;
            row_o  <= addr[ROW_W-1:0];
            ap_o   <= 1'b0;
          end
          CMD_RD, CMD_WR: begin
            bank_o <= ba;
            row_o  <= rows[ba];
            col_o  <= addr[COL_W-1:0];
            ap_o   <= flag;
          end
          CMD_PRE: begin
            bank_o <= ba;
            ap_o   <= flag;
          end
          CMD_NOP: ;
          default: ap_o <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdram_cmd_ctrl_chk.sv
module sdram_cmd_ctrl_chk #(
  parameter int NUM_BANKS = 4,
  localparam int BA_W     = $clog2(NUM_BANKS)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cs_n,
  input logic [2:0]           cmd_o,
  input logic                 err_o,
  input logic [BA_W-1:0]      bank_o,
  input logic [2:0]           bl_o,
  input logic                 bt_o,
  input logic [2:0]           cl_o,
  input logic                 dll_rst_o,
  input logic [NUM_BANKS-1:0] open_o
);

  logic [NUM_BANKS-1:0] prev_open;

  always_ff @(posedge clk) begin
    if (rst) prev_open <= '0;
    else     prev_open <= open_o;
  end

  AST_ERR_NOT_ISSUED: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (cmd_o == 3'd0)); // R4

  AST_CS_HIGH_NOP: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(cs_n)) |-> (cmd_o == 3'd0 && !err_o)); // R1

  AST_ACCESS_OPEN: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd2 || cmd_o == 3'd3) |-> prev_open[bank_o]); // R4

  AST_REF_CLOSED: assert property (@(posedge clk) disable iff (rst)
    (cmd_o == 3'd5) |-> (prev_open == '0)); // R7

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (bl_o != 3'd0 && bl_o <= 3'd3) &&
    (cl_o == 3'd2 || cl_o == 3'd6 || cl_o == 3'd3)); // R9

  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != 3'd6) |-> $stable({bl_o, bt_o, cl_o})); // R8

  AST_DLL_WITH_MRS: assert property (@(posedge clk) disable iff (rst)
    dll_rst_o |-> (cmd_o == 3'd6)); // R10

  AST_DLL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    dll_rst_o |=> !dll_rst_o); // R10

endmodule

bind sdram_cmd_ctrl sdram_cmd_ctrl_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cs_n     (cs_n),
  .cmd_o    (cmd_o),
  .err_o    (err_o),
  .bank_o   (bank_o),
  .bl_o     (bl_o),
  .bt_o     (bt_o),
  .cl_o     (cl_o),
  .dll_rst_o(dll_rst_o),
  .open_o   (open_o)
);

// File: tb/sdram_cmd_ctrl_bench.sv
module sdram_cmd_ctrl_bench;

  localparam int PERIOD  = 20;
  localparam int TIMEOUT = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0]  ba = '0;
  logic [12:0] addr = '0;
  logic [2:0]  cmd_o;
  logic        err_o;
  logic [1:0]  bank_o;
  logic [12:0] row_o;
  logic [9:0]  col_o;
  logic        ap_o;
  logic [2:0]  bl_o;
  logic        bt_o;
  logic [2:0]  cl_o;
  logic        dll_rst_o;
  logic [3:0]  open_o;

  always #(PERIOD/2) clk = ~clk;

  sdram_cmd_ctrl u_sdram_cmd_ctrl (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .addr(addr), .cmd_o(cmd_o), .err_o(err_o),
    .bank_o(bank_o), .row_o(row_o), .col_o(col_o), .ap_o(ap_o),
    .bl_o(bl_o), .bt_o(bt_o), .cl_o(cl_o), .dll_rst_o(dll_rst_o),
    .open_o(open_o)
  );

  int errors = 0;
  int checks = 0;

  // reference state
  bit   m_open [4];
  int   m_cnt  [4];
  logic [12:0] m_row [4];
  logic [2:0]  m_bl = 3'b010, m_cl = 3'b010;
  logic        m_bt = 1'b0, m_pend = 1'b0;
  logic [2:0]  e_cmd = 0;
  logic        e_err = 0, e_dll = 0, e_ap = 0;
  logic [1:0]  e_bank = 0;
  logic [12:0] e_row = 0;
  logic [9:0]  e_col = 0;
  string       tag = "R12";

  task automatic chk(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, got, exp);
    end
  endtask

  function automatic logic bl_ok(input logic [2:0] c);
    return c == 3'd1 || c == 3'd2 || c == 3'd3;
  endfunction

  function automatic logic cl_ok(input logic [2:0] c);
    return c == 3'd2 || c == 3'd6 || c == 3'd3;
  endfunction

  function automatic logic [3:0] open_vec();
    logic [3:0] v;
    for (int b = 0; b < 4; b++) v[b] = m_open[b];
    return v;
  endfunction

  task automatic model(input logic cs, input logic [2:0] pins,
                       input logic [1:0] b, input logic [12:0] a);
    logic [2:0] raw;
    logic ok;
    logic [5:0] up;
    raw = 3'd0;
    if (!cs) begin
      case (pins)
        3'b011: raw = 3'd1;
        3'b101: raw = 3'd2;
        3'b100: raw = 3'd3;
        3'b010: raw = 3'd4;
        3'b001: raw = 3'd5;
        3'b000: raw = 3'd6;
        3'b110: raw = 3'd7;
        default: raw = 3'd0;
      endcase
    end
    ok = 1'b1;
    tag = cs ? "R1" : "R2";
    up = a[12:7];
    case (raw)
      3'd1: begin tag = "R3"; ok = !m_open[b]; if (m_cnt[b] != 0) tag = "R6"; end
      3'd2, 3'd3: begin
        tag = (m_cnt[b] != 0 || a[10]) ? "R6" : "R4";
        ok = m_open[b] && m_cnt[b] == 0;
      end
      3'd4: tag = "R5";
      3'd5: begin tag = "R7"; ok = (open_vec() == 0); end
      3'd6: begin
        if (b != 0 || !(up == 0 || up == 6'b000010)) begin tag = "R11"; ok = 0; end
        else if (!bl_ok(a[2:0]) || !cl_ok(a[6:4])) begin tag = "R9"; ok = 0; end
        else if (up == 6'b000010) begin tag = "R10"; ok = !m_pend; end
        else tag = "R8";
      end
      default: ;
    endcase
    // countdown of auto-precharge
    for (int k = 0; k < 4; k++) begin
      if (m_cnt[k] > 0) begin
        m_cnt[k]--;
        if (m_cnt[k] == 0) m_open[k] = 0;
      end
    end
    e_cmd = ok ? raw : 3'd0;
    e_err = !ok;
    e_dll = 1'b0;
    if (ok) begin
      case (raw)
        3'd1: begin m_open[b] = 1; m_row[b] = a; e_bank = b; e_row = a; e_ap = 0; end
        3'd2, 3'd3: begin
          e_bank = b; e_row = m_row[b]; e_col = a[9:0]; e_ap = a[10];
          if (a[10]) m_cnt[b] = 1 << (m_bl - 1);
        end
        3'd4: begin
          e_bank = b; e_ap = a[10];
          for (int k = 0; k < 4; k++)
            if (a[10] || k == int'(b)) begin m_open[k] = 0; m_cnt[k] = 0; end
        end
        3'd5, 3'd7: e_ap = 0;
        3'd6: begin
          e_ap = 0;
          m_bl = a[2:0]; m_bt = a[3]; m_cl = a[6:4];
          m_pend = (up == 6'b000010);
          e_dll = m_pend;
        end
        default: ;
      endcase
    end
  endtask

  task automatic check_all();
    chk(tag, "cmd_o", cmd_o, e_cmd);
    chk(tag, "err_o", err_o, e_err);
    chk(tag, "dll_rst_o", dll_rst_o, e_dll);
    chk(tag, "open_o", open_o, open_vec());
    chk(tag, "bank_o", bank_o, e_bank);
    chk(tag, "row_o", row_o, e_row);
    chk(tag, "col_o", col_o, e_col);
    chk(tag, "ap_o", ap_o, e_ap);
    chk(tag, "mode", {bl_o, bt_o, cl_o}, {m_bl, m_bt, m_cl});
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic step(input logic cs, input logic [2:0] pins,
                      input logic [1:0] b, input logic [12:0] a);
    cs_n = cs; {ras_n, cas_n, we_n} = pins; ba = b; addr = a;
    model(cs, pins, b, a);
    @(negedge clk);
    check_all();
  endtask

  localparam logic [2:0] P_ACT = 3'b011, P_RD = 3'b101, P_WR = 3'b100,
                         P_PRE = 3'b010, P_REF = 3'b001, P_MRS = 3'b000,
                         P_NOP = 3'b111, P_BST = 3'b110;

  function automatic logic [12:0] mode_word(input logic [5:0] up, input logic [2:0] cl,
                                            input logic bt, input logic [2:0] bl);
    return {up, cl, bt, bl};
  endfunction

  function automatic logic [2:0] rand_cl();
    case ($urandom % 3)
      0: return 3'b010;
      1: return 3'b110;
      default: return 3'b011;
    endcase
  endfunction

  initial begin
    #(PERIOD * TIMEOUT);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 4; k++) begin m_open[k] = 0; m_cnt[k] = 0; m_row[k] = 0; end
    repeat (3) @(negedge clk);
    tag = "R12";
    check_all();                                   // R12 reset state
    rst = 1'b0;
    // directed corner cases
    step(1'b1, P_MRS, 2'd0, 13'h1FFF);               // R1 deselected
    step(1'b0, P_RD, 2'd1, 13'h0010);                // R4 read closed bank
    step(1'b0, P_ACT, 2'd0, 13'h1ABC);               // R3
    step(1'b0, P_ACT, 2'd0, 13'h0001);               // R3 already open
    step(1'b0, P_ACT, 2'd2, 13'h0005);
    step(1'b0, P_WR, 2'd0, 13'h0155);                // R4
    step(1'b0, P_MRS, 2'd0, mode_word(6'd0, 3'b011, 1'b1, 3'b011)); // R8 BL8
    step(1'b0, P_RD, 2'd2, 13'h0407);                // R6 auto-precharge
    step(1'b0, P_RD, 2'd2, 13'h0007);                // R6 busy
    step(1'b0, P_NOP, 2'd0, 13'h0);
    step(1'b0, P_BST, 2'd0, 13'h0);                  // R2
    step(1'b0, P_ACT, 2'd2, 13'h0009);               // R6 edge k+4 still closing
    step(1'b0, P_ACT, 2'd2, 13'h0009);               // R6 reopen allowed
    step(1'b0, P_REF, 2'd0, 13'h0);                  // R7 rejected
    step(1'b0, P_PRE, 2'd1, 13'h0400);               // R5 all
    step(1'b0, P_REF, 2'd0, 13'h0);                  // R7 accepted
    step(1'b0, P_MRS, 2'd0, mode_word(6'b000010, 3'b110, 1'b0, 3'b001)); // R10
    step(1'b0, P_MRS, 2'd0, mode_word(6'b000010, 3'b010, 1'b0, 3'b010)); // R10 rejected
    step(1'b0, P_MRS, 2'd0, mode_word(6'd0, 3'b010, 1'b0, 3'b001));      // R8 clears
    step(1'b0, P_MRS, 2'd0, mode_word(6'b000001, 3'b010, 1'b0, 3'b010)); // R11
    step(1'b0, P_MRS, 2'd1, mode_word(6'd0, 3'b010, 1'b0, 3'b010));      // R11 bank
    step(1'b0, P_MRS, 2'd0, mode_word(6'd0, 3'b010, 1'b0, 3'b000));      // R9 BL
    step(1'b0, P_MRS, 2'd0, mode_word(6'd0, 3'b001, 1'b0, 3'b010));      // R9 CL
    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      logic [1:0] b;
      logic [12:0] a;
      r = $urandom % 100;
      b = 2'($urandom);
      a = 13'($urandom);
      if (r < 8) step(1'b1, 3'($urandom), b, a);
      else if (r < 32) step(1'b0, P_ACT, b, a);
      else if (r < 52) begin
        a[10] = ($urandom % 3 == 0);
        step(1'b0, ($urandom % 2) ? P_RD : P_WR, b, a);
      end
      else if (r < 62) begin
        a[10] = ($urandom % 4 == 0);
        step(1'b0, P_PRE, b, a);
      end
      else if (r < 66) step(1'b0, P_REF, b, a);
      else if (r < 78) begin
        logic [5:0] up;
        logic [1:0] mb;
        logic [2:0] bl, cl;
        mb = 2'd0; up = 6'd0;
        bl = 3'd1 + 3'($urandom % 3);
        cl = rand_cl();
        case ($urandom % 6)
          0, 1: ;
          2: up = 6'b000010;
          3: begin up = 6'($urandom); if (up == 0 || up == 6'b000010) up = 6'b100000; end
          4: if ($urandom % 2) bl = 3'd4 + 3'($urandom % 4); else cl = 3'd0;
          default: mb = 2'd1 + 2'($urandom % 3);
        endcase
        step(1'b0, P_MRS, mb, mode_word(up, cl, 1'($urandom), bl));
      end
      else step(1'b0, ($urandom % 2) ? P_NOP : P_BST, b, a);
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule